// File: doc/BRIEF.md
# Bridge Configuration Request Router

This block sits on the upstream side of a PCI-to-PCI bridge and classifies each configuration request that arrives there. A request carries a cycle-type flag (Type 0 or Type 1), a bus number, a device number, a function number, a dword register index, a read/write flag and write data. The block compares the target bus with two bus-number inputs: `sec_bus` is the bus directly behind the bridge, and `sub_bus` is the highest bus number reachable through it.

The block sorts each request into one of four outcomes:
- A local outcome, for a Type 0 request that a local target has claimed.
- A conversion to a Type 0 cycle on the secondary bus. The device number is turned into a one-hot select vector.
- An unchanged forward of a Type 1 request further downstream.
- A master abort. An aborted write is discarded, and an aborted read returns all ones.

Requests enter on a valid/ready channel. Results leave on a second valid/ready channel through a one-entry output register, so a result appears the cycle after its request is accepted. While a result waits because `out_ready` is low, the result is held unchanged and `in_ready` is low. The input side therefore takes a new request only when the output register is empty or is being drained in the same cycle. A single-cycle strobe marks each convert, forward or abort result at the moment it is handed off.

Top module: `cfg_route_top`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and no strobe is active.
- R2: A Type 0 request (`in_type1`=0) is never converted or forwarded. If `in_t0_claimed` is 1, it yields `out_kind`=0 (local). Otherwise it yields `out_kind`=3 (abort).
- R3: A Type 1 request whose bus is nonzero and equals `sec_bus` yields `out_kind`=1 (convert). In that case `out_type1` is 0 and `out_idsel` has only bit `in_dev` set. The bus, device, function, register, write flag and write data are carried through.
- R4: A Type 1 request whose bus is nonzero, greater than `sec_bus` and no greater than `sub_bus` yields `out_kind`=2 (forward). All fields are passed unchanged, with `out_type1`=1 and `out_idsel`=0.
- R5: Any other Type 1 request yields `out_kind`=3 (abort) with `out_idsel`=0.
- R6: A request to bus 0 is never converted or forwarded, whatever the values of `sec_bus` and `sub_bus`, including when both are 0.
- R7: On an abort, a read gives `out_rdata`=32'hFFFF_FFFF, and a write gives `out_wdata`=0. For every non-abort outcome, `out_rdata` is 0.
- R8: A request accepted at one clock edge is presented on `out_valid` after that edge. Exactly one of `stb_convert`, `stb_forward` or `stb_abort` is high during the handoff cycle (`out_valid` and `out_ready` both high) of a result of that kind. No strobe is high at any other time, or for a local result.
- R9: While `out_valid` is 1 and `out_ready` is 0, the result stays stable and `in_ready` is 0. Otherwise `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_bus | input | 8 | Bus number directly behind the bridge |
| sub_bus | input | 8 | Highest bus number reachable behind the bridge |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_type1 | input | 1 | 1 = Type 1 request, 0 = Type 0 |
| in_t0_claimed | input | 1 | A local target claims a Type 0 request |
| in_bus | input | 8 | Target bus number |
| in_dev | input | 5 | Target device number |
| in_func | input | 3 | Target function number |
| in_reg | input | 6 | Dword register index |
| in_we | input | 1 | 1 = write, 0 = read |
| in_wdata | input | 32 | Write data |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | 0 local, 1 convert, 2 forward, 3 abort |
| out_type1 | output | 1 | Cycle type of the emitted request |
| out_bus | output | 8 | Bus number |
| out_dev | output | 5 | Device number |
| out_func | output | 3 | Function number |
| out_reg | output | 6 | Dword register index |
| out_idsel | output | 32 | One-hot device select on convert, else 0 |
| out_we | output | 1 | Write flag |
| out_wdata | output | 32 | Write data, 0 on abort |
| out_rdata | output | 32 | Completion data for an aborted read |
| stb_convert | output | 1 | Convert result handed off |
| stb_forward | output | 1 | Forward result handed off |
| stb_abort | output | 1 | Abort result handed off |

## Verification
A window comparison that goes wrong shows up at the ports as a wrong `out_kind` and a wrong strobe. This is visible in the very cycle after the request is accepted. The boundary buses are the cases that expose it: `sec_bus` itself, `sec_bus`+1, `sub_bus`, `sub_bus`+1 and bus 0. A stale or lost output register shows up as a mismatch between `out_valid` and `in_ready` within one cycle of a stalled handoff. It also shows up as a result that changes while `out_ready` is held low.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL   = 2'd0,
    RT_CONVERT = 2'd1,
    RT_FORWARD = 2'd2,
    RT_ABORT   = 2'd3
  } route_e;
endpackage

// File: rtl/cfg_bus_window.sv
module cfg_bus_window
  import cfg_route_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             is_type1,
  input  logic             t0_claimed,
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec,
  input  logic [BUS_W-1:0] sub,
  output route_e           route
);
  logic nonzero;
  logic hit_sec;
  logic hit_below;

  assign nonzero   = (bus != '0);
  assign hit_sec   = nonzero && (bus == sec);
  assign hit_below = nonzero && (bus > sec) && (bus <= sub);

  always_comb begin
    if (!is_type1)      route = t0_claimed ? RT_LOCAL : RT_ABORT;
    else if (hit_sec)   route = RT_CONVERT;
    else if (hit_below) route = RT_FORWARD;
    else                route = RT_ABORT;
  end
endmodule

// File: rtl/cfg_idsel_dec.sv
module cfg_idsel_dec #(
  parameter int DEV_W = 5,
  localparam int SEL_W = 1 << DEV_W
) (
  input  logic             en,
  input  logic [DEV_W-1:0] dev,
  output logic [SEL_W-1:0] sel
);
  for (genvar g = 0; g < SEL_W; g++) begin : g_line
    assign sel[g] = en && (dev == DEV_W'(g));
  end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfg_route_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int REG_W  = 6,
  parameter int DATA_W = 32,
  localparam int SEL_W = 1 << DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_type1,
  input  logic              in_t0_claimed,
  input  logic [BUS_W-1:0]  in_bus,
  input  logic [DEV_W-1:0]  in_dev,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [REG_W-1:0]  in_reg,
  input  logic              in_we,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic              out_type1,
  output logic [BUS_W-1:0]  out_bus,
  output logic [DEV_W-1:0]  out_dev,
  output logic [FUNC_W-1:0] out_func,
  output logic [REG_W-1:0]  out_reg,
  output logic [SEL_W-1:0]  out_idsel,
  output logic              out_we,
  output logic [DATA_W-1:0] out_wdata,
  output logic [DATA_W-1:0] out_rdata,
  output logic              stb_convert,
  output logic              stb_forward,
  output logic              stb_abort
);
  route_e             route;
  logic [SEL_W-1:0]   sel;
  logic               take;
  logic               give;
  logic               is_abort;

  cfg_bus_window #(.BUS_W(BUS_W)) u_window (
    .is_type1  (in_type1),
    .t0_claimed(in_t0_claimed),
    .bus       (in_bus),
    .sec       (sec_bus),
    .sub       (sub_bus),
    .route     (route)
  );

  cfg_idsel_dec #(.DEV_W(DEV_W)) u_idsel (
    .en (route == RT_CONVERT),
    .dev(in_dev),
    .sel(sel)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign give     = out_valid && out_ready;
  assign is_abort = (route == RT_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= RT_LOCAL;
      out_type1 <= 1'b0;
      out_bus   <= '0;
      out_dev   <= '0;
      out_func  <= '0;
      out_reg   <= '0;
      out_idsel <= '0;
      out_we    <= 1'b0;
      out_wdata <= '0;
      out_rdata <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_kind  <= route;
      out_type1 <= in_type1 && (route != RT_CONVERT);
      out_bus   <= in_bus;
      out_dev   <= in_dev;
      out_func  <= in_func;
      out_reg   <= in_reg;
      out_idsel <= sel;
      out_we    <= in_we;
      out_wdata <= is_abort ? '0 : in_wdata;
      out_rdata <= (is_abort && !in_we) ? '1 : '0;
    end else if (give) begin
      out_valid <= 1'b0;
    end
  end

  assign stb_convert = give && (out_kind == RT_CONVERT);
  assign stb_forward = give && (out_kind == RT_FORWARD);
  assign stb_abort   = give && (out_kind == RT_ABORT);

  // R8: an accepted request is visible on the next cycle
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R9: stalled result holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_bus) && $stable(out_wdata) && $stable(out_idsel)));

  // R3: converted cycle selects exactly one device and is Type 0
  a_r3_convert_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == RT_CONVERT) |-> ($onehot(out_idsel) && !out_type1));

  // R7: aborted read returns all ones
  a_r7_abort_read: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == RT_ABORT && !out_we) |-> (out_rdata == '1));

  // R6: bus zero never goes downstream
  a_r6_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bus == '0) |-> (out_kind == RT_LOCAL || out_kind == RT_ABORT));

  // R4: forwarded result carries no device select
  a_r4_forward_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == RT_FORWARD) |-> (out_type1 && out_idsel == '0));
endmodule

// File: tb/test_cfg_route_top.sv
module test_cfg_route_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sec_bus = '0, sub_bus = '0;
  logic        in_valid = 1'b0, in_type1 = 1'b0, in_t0_claimed = 1'b0, in_we = 1'b0;
  logic [7:0]  in_bus = '0;
  logic [4:0]  in_dev = '0;
  logic [2:0]  in_func = '0;
  logic [5:0]  in_reg = '0;
  logic [31:0] in_wdata = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_type1, out_we;
  logic [1:0]  out_kind;
  logic [7:0]  out_bus;
  logic [4:0]  out_dev;
  logic [2:0]  out_func;
  logic [5:0]  out_reg;
  logic [31:0] out_idsel, out_wdata, out_rdata;
  logic        stb_convert, stb_forward, stb_abort;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    int kind; bit t1; int bus; int dev; int func; int rg;
    logic [31:0] idsel; bit we; logic [31:0] wdata; logic [31:0] rdata;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  cfg_route_top i_cfg_route_top (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input bit t1, input bit cl, input int bus,
      input int dev, input int func, input int rg, input bit we,
      input logic [31:0] wd, input int sec, input int sub);
    exp_t e;
    if (!t1) e.kind = cl ? 0 : 3;
    else if (bus != 0 && bus == sec) e.kind = 1;
    else if (bus != 0 && bus > sec && bus <= sub) e.kind = 2;
    else e.kind = 3;
    e.t1 = (e.kind == 1) ? 1'b0 : t1;
    e.bus = bus; e.dev = dev; e.func = func; e.rg = rg; e.we = we;
    e.idsel = (e.kind == 1) ? (32'd1 << dev) : 32'd0;
    e.wdata = (e.kind == 3) ? 32'd0 : wd;
    e.rdata = (e.kind == 3 && !we) ? 32'hFFFF_FFFF : 32'd0;
    return e;
  endfunction

  // reference model advance on every edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit acc;
      acc = in_valid && (q.size() == 0 || out_ready);
      if (q.size() != 0 && out_ready) void'(q.pop_front());
      if (acc) q.push_back(model(in_type1, in_t0_claimed, in_bus, in_dev, in_func,
                                 in_reg, in_we, in_wdata, sec_bus, sub_bus));
    end
  end

  // comparison on every clock, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      string rk;
      chk(out_valid == (q.size() != 0), "R8", "out_valid", out_valid, q.size() != 0);
      chk(in_ready == (q.size() == 0 || out_ready), "R9", "in_ready", in_ready,
          q.size() == 0 || out_ready);
      if (q.size() != 0 && out_valid) begin
        exp_t e;
        e = q[0];
        if (e.bus == 0 && e.t1) rk = "R6";
        else if (!e.t1 && e.kind != 1) rk = "R2";
        else if (e.kind == 1) rk = "R3";
        else if (e.kind == 2) rk = "R4";
        else rk = "R5";
        chk(out_kind == e.kind, rk, "kind", out_kind, e.kind);
        chk(out_type1 == e.t1 && out_bus == e.bus && out_dev == e.dev &&
            out_func == e.func && out_reg == e.rg && out_we == e.we, rk, "fields",
            {out_type1, out_bus, out_dev, out_func, out_reg, out_we},
            {e.t1, e.bus[7:0], e.dev[4:0], e.func[2:0], e.rg[5:0], e.we});
        chk(out_idsel == e.idsel, rk, "idsel", out_idsel, e.idsel);
        chk(out_wdata == e.wdata && out_rdata == e.rdata, "R7", "data",
            {out_wdata, out_rdata}, {e.wdata, e.rdata});
        chk(stb_convert == (out_ready && e.kind == 1) &&
            stb_forward == (out_ready && e.kind == 2) &&
            stb_abort == (out_ready && e.kind == 3), "R8", "strobes",
            {stb_convert, stb_forward, stb_abort},
            {out_ready && e.kind == 1, out_ready && e.kind == 2, out_ready && e.kind == 3});
      end else begin
        chk(!stb_convert && !stb_forward && !stb_abort, "R8", "idle strobes",
            {stb_convert, stb_forward, stb_abort}, 0);
      end
    end
  end

  task automatic send(input bit t1, input bit cl, input int bus, input int dev,
                      input bit we, input logic [31:0] wd);
    @(negedge clk);
    in_valid = 1'b1; in_type1 = t1; in_t0_claimed = cl; in_bus = bus[7:0];
    in_dev = dev[4:0]; in_func = 3'(dev + 1); in_reg = 6'(bus + dev);
    in_we = we; in_wdata = wd;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 0 && in_ready == 1, "R1", "reset outputs", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!stb_convert && !stb_forward && !stb_abort && !out_valid, "R1", "after reset",
        {stb_convert, stb_forward, stb_abort, out_valid}, 0);
    // R6: both windows at zero
    send(1, 0, 0, 3, 0, 0);
    sec_bus = 8'd4; sub_bus = 8'd9;
    // R2 Type 0 claimed / unclaimed
    send(0, 1, 4, 2, 0, 0);
    send(0, 0, 4, 2, 1, 32'h1234);
    // R3 exact secondary, R4 range edges, R5 outside
    send(1, 0, 4, 31, 1, 32'hDEAD_BEEF);
    send(1, 0, 4, 0, 0, 0);
    send(1, 0, 5, 7, 1, 32'h55);
    send(1, 0, 9, 7, 0, 0);
    send(1, 0, 10, 7, 0, 0);
    send(1, 0, 3, 7, 1, 32'h77);
    send(1, 0, 0, 7, 0, 0);
    // R9 back-pressure with random traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) begin
        sec_bus = 8'($urandom_range(0, 6)); sub_bus = 8'($urandom_range(0, 12));
      end
      @(negedge clk);
      out_ready = ($urandom_range(0, 2) != 0);
      in_valid = ($urandom_range(0, 3) != 0);
      in_type1 = ($urandom_range(0, 4) != 0);
      in_t0_claimed = $urandom_range(0, 1);
      in_bus = 8'($urandom_range(0, 13));
      in_dev = 5'($urandom); in_func = 3'($urandom); in_reg = 6'($urandom);
      in_we = $urandom_range(0, 1); in_wdata = $urandom;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule